// File: doc/BRIEF.md
# Shadow Memory Region Attribute Controller

This block holds a handful of 16-bit configuration registers and turns them into per-region access attributes for the top half of the first megabyte of memory (0x80000 to 0xFFFFF). That window is split into sixteen 32 KB segments. Each segment is marked as forwarded to the external bus, served internally with reads and writes, or served internally as read-only. A memory decoder reads the registered attribute table, or asks the combinational lookup port for the attribute of any 20-bit address.

There are two decode modes. In coarse mode the memory-control register controls four 128 KB regions. In extended mode eight 32 KB segments over 0xC0000 to 0xFFFFF each take their own enable bit and their own read-only bit. A lock bit in the memory-control register has two effects. It turns enabled coarse ROM shadows into read-only, and it stops further writes from changing the table until a later write clears it. A separate output reports the attribute of the system ROM base segment. Which segment that is depends on a ROM-size bit.

Top module: `shadow_attr_ctrl`

## Requirements
- R1: After reset the registers at 0x22, 0x2C and 0x2E read 0 and the register at 0x28 reads 0xF9. Every segment of the table is external (00), and the block is unlocked.
- R2: The registers at 0x22, 0x28, 0x2C and 0x2E store any written 16-bit value and read it back on `cfg_rdata`, even while locked. A write to any other address changes nothing, and a read from any other address returns 0.
- R3: Attributes use the code 00 external, 01 internal read/write, 10 internal read-only. Code 11 never appears. The table changes only on the second rising edge after an accepted write: the first edge stores the register, the second updates the table.
- R4: Segments 0–3 (0x80000–0x9FFFF) are read/write when bit 3 of register 0x22 is set, and external when it is clear.
- R5: Segments 4–7 (0xA0000–0xBFFFF) are external when bit 10 of register 0x22 is clear. When bit 10 is set they are read/write if bit 11 is 1 and read-only if bit 11 is 0. The lock bit has no effect on them.
- R6: In coarse mode (register 0x2C bit 0 clear), segments 8–11 follow bit 9 of register 0x22 and segments 12–15 follow bit 0. A clear enable bit gives external. A set enable bit gives read/write, or read-only when bit 15 of register 0x22 is set.
- R7: A write is accepted only if bit 15 of register 0x22 was clear before that write. While the lock bit is set, writes change only the register contents and never the table. A write that clears bit 15 unlocks the block for the next write only; the clearing write itself does not update the table.
- R8: In extended mode (register 0x2C bit 0 set), segment 8+i covers 0xC0000+i·0x8000 for i = 0..7. It is external when bit i+8 of register 0x2E is clear. When that bit is set, the segment is read-only if bit i is 1 and read/write if bit i is 0.
- R9: `probe_attr` is 01 for any `probe_addr` below 0x80000. Otherwise it equals the table entry of segment (probe_addr−0x80000)/0x8000, and it is combinational.
- R10: `sysrom_attr` equals the table entry of segment 12 (0xE0000) when bit 8 of register 0x22 is set, and of segment 14 (0xF0000) when that bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address for both write and read |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data of `cfg_addr`, combinational |
| seg_attr | output | 32 | Attribute table, segment k in bits [2k+1:2k] |
| probe_addr | input | 20 | Memory address to look up |
| probe_attr | output | 2 | Attribute of `probe_addr` |
| sysrom_attr | output | 2 | Attribute of the system ROM base segment |

## Verification
Two things can land in the same cycle. The first is the pending table update from a write that sets the lock. The second is the next write, which that lock must now reject. The bench provokes this with back-to-back writes in extended mode: a lock-setting write to 0x22 followed at once by a write to 0x2E. It then checks that the table matches the registers as they stood after the first write, and that the second value is stored and readable but has no effect on the table. It also checks, one cycle after a write, that the table still holds its old value, which pins the update to the second edge.

// File: rtl/shadow_attr_pkg.sv
package shadow_attr_pkg;

  localparam logic [1:0] ATTR_EXT = 2'b00;
  localparam logic [1:0] ATTR_RW  = 2'b01;
  localparam logic [1:0] ATTR_RO  = 2'b10;

  localparam logic [7:0] ADR_MEMCTL = 8'h22;
  localparam logic [7:0] ADR_AUX    = 8'h28;
  localparam logic [7:0] ADR_GRANEN = 8'h2C;
  localparam logic [7:0] ADR_XGRAN  = 8'h2E;
  localparam logic [15:0] AUX_RESET = 16'h00F9;

  // Bit positions within the memory-control register
  localparam int MC_BASE640 = 3;
  localparam int MC_VID_EN  = 10;
  localparam int MC_VID_RW  = 11;
  localparam int MC_OPT_EN  = 9;
  localparam int MC_SYS_EN  = 0;
  localparam int MC_ROMSZ   = 8;
  localparam int MC_LOCK    = 15;

  function automatic logic [1:0] shadow_code(input logic en, input logic ro);
    if (!en) return ATTR_EXT;
    return ro ? ATTR_RO : ATTR_RW;
  endfunction

  // Attribute of segment k (0..15, 32 KB each from 0x80000) from register contents
  function automatic logic [1:0] segment_attr(input int k, input logic [15:0] mc,
                                              input logic [15:0] ge, input logic [15:0] xg);
    logic [1:0] a;
    int j;
    a = ATTR_EXT;
    if (k < 4)
      a = mc[MC_BASE640] ? ATTR_RW : ATTR_EXT;
    else if (k < 8)
      a = shadow_code(mc[MC_VID_EN], !mc[MC_VID_RW]);
    else if (ge[0]) begin
      j = k - 8;
      a = shadow_code(xg[j + 8], xg[j]);
    end else if (k < 12)
      a = shadow_code(mc[MC_OPT_EN], mc[MC_LOCK]);
    else
      a = shadow_code(mc[MC_SYS_EN], mc[MC_LOCK]);
    return a;
  endfunction

endpackage

// File: rtl/shadow_cfg_regs.sv
module shadow_cfg_regs
  import shadow_attr_pkg::*;
#(
  parameter int CFG_AW = 8,
  parameter int CFG_DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  output logic [CFG_DW-1:0] reg_mc,
  output logic [CFG_DW-1:0] reg_ge,
  output logic [CFG_DW-1:0] reg_xg,
  output logic              accept
);

  logic [CFG_DW-1:0] reg_aux;
  logic hit_mc, hit_aux, hit_ge, hit_xg;

  assign hit_mc  = (cfg_addr == CFG_AW'(ADR_MEMCTL));
  assign hit_aux = (cfg_addr == CFG_AW'(ADR_AUX));
  assign hit_ge  = (cfg_addr == CFG_AW'(ADR_GRANEN));
  assign hit_xg  = (cfg_addr == CFG_AW'(ADR_XGRAN));

  // Lock is judged on the value held before this write
  assign accept = cfg_wr && (hit_mc || hit_aux || hit_ge || hit_xg) && !reg_mc[MC_LOCK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_mc  <= '0;
      reg_aux <= CFG_DW'(AUX_RESET);
      reg_ge  <= '0;
      reg_xg  <= '0;
    end else if (cfg_wr) begin
      if (hit_mc)  reg_mc  <= cfg_wdata;
      if (hit_aux) reg_aux <= cfg_wdata;
      if (hit_ge)  reg_ge  <= cfg_wdata;
      if (hit_xg)  reg_xg  <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (hit_mc)  cfg_rdata = reg_mc;
    if (hit_aux) cfg_rdata = reg_aux;
    if (hit_ge)  cfg_rdata = reg_ge;
    if (hit_xg)  cfg_rdata = reg_xg;
  end

endmodule

// File: rtl/shadow_seg_table.sv
module shadow_seg_table
  import shadow_attr_pkg::*;
#(
  parameter int NUM_SEG = 16,
  parameter int CFG_DW  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic [CFG_DW-1:0]    reg_mc,
  input  logic [CFG_DW-1:0]    reg_ge,
  input  logic [CFG_DW-1:0]    reg_xg,
  output logic [2*NUM_SEG-1:0] seg_attr
);

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        seg_attr[2*k +: 2] <= ATTR_EXT;
      else if (upd)
        seg_attr[2*k +: 2] <= segment_attr(k, 16'(reg_mc), 16'(reg_ge), 16'(reg_xg));
    end
  end

endmodule

// File: rtl/shadow_addr_lookup.sv
module shadow_addr_lookup
  import shadow_attr_pkg::*;
#(
  parameter int MEM_AW   = 20,
  parameter int SEG_BITS = 15,
  parameter int NUM_SEG  = 16
) (
  input  logic [MEM_AW-1:0]    probe_addr,
  input  logic [2*NUM_SEG-1:0] seg_attr,
  input  logic                 rom_small,
  output logic [1:0]           probe_attr,
  output logic [1:0]           sysrom_attr
);

  localparam logic [MEM_AW-1:0] WIN_BASE = MEM_AW'((1 << MEM_AW) - (NUM_SEG << SEG_BITS));
  localparam int SYS_LO = NUM_SEG - 4;
  localparam int SYS_HI = NUM_SEG - 2;

  function automatic int seg_index(input logic [MEM_AW-1:0] a);
    return int'((a - WIN_BASE) >> SEG_BITS);
  endfunction

  int idx;
  assign idx = seg_index(probe_addr);

  always_comb begin
    if (probe_addr < WIN_BASE) probe_attr = ATTR_RW;
    else                       probe_attr = seg_attr[2*idx +: 2];
  end

  assign sysrom_attr = rom_small ? seg_attr[2*SYS_LO +: 2] : seg_attr[2*SYS_HI +: 2];

endmodule

// File: rtl/shadow_attr_ctrl.sv
module shadow_attr_ctrl
  import shadow_attr_pkg::*;
#(
  parameter int CFG_AW   = 8,
  parameter int CFG_DW   = 16,
  parameter int MEM_AW   = 20,
  parameter int SEG_BITS = 15,
  parameter int NUM_SEG  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [CFG_DW-1:0]    cfg_wdata,
  output logic [CFG_DW-1:0]    cfg_rdata,
  output logic [2*NUM_SEG-1:0] seg_attr,
  input  logic [MEM_AW-1:0]    probe_addr,
  output logic [1:0]           probe_attr,
  output logic [1:0]           sysrom_attr
);

  logic [CFG_DW-1:0] reg_mc, reg_ge, reg_xg;
  logic accept_w;   // write that may recompute the table
  logic upd_q;      // table recompute strobe, one edge after accept_w
  logic cfg_lock;   // lock bit currently stored

  shadow_cfg_regs #(.CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .reg_mc(reg_mc),
    .reg_ge(reg_ge), .reg_xg(reg_xg), .accept(accept_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= accept_w;
  end

  assign cfg_lock = reg_mc[MC_LOCK];

  shadow_seg_table #(.NUM_SEG(NUM_SEG), .CFG_DW(CFG_DW)) u_table (
    .clk(clk), .rst_n(rst_n), .upd(upd_q), .reg_mc(reg_mc),
    .reg_ge(reg_ge), .reg_xg(reg_xg), .seg_attr(seg_attr)
  );

  shadow_addr_lookup #(.MEM_AW(MEM_AW), .SEG_BITS(SEG_BITS), .NUM_SEG(NUM_SEG)) u_lookup (
    .probe_addr(probe_addr), .seg_attr(seg_attr), .rom_small(reg_mc[MC_ROMSZ]),
    .probe_attr(probe_attr), .sysrom_attr(sysrom_attr)
  );

endmodule

// File: rtl/shadow_attr_chk.sv
module shadow_attr_chk
  import shadow_attr_pkg::*;
#(
  parameter int CFG_AW   = 8,
  parameter int CFG_DW   = 16,
  parameter int MEM_AW   = 20,
  parameter int SEG_BITS = 15,
  parameter int NUM_SEG  = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_wr,
  input logic [CFG_AW-1:0]    cfg_addr,
  input logic [CFG_DW-1:0]    cfg_rdata,
  input logic [2*NUM_SEG-1:0] seg_attr,
  input logic [MEM_AW-1:0]    probe_addr,
  input logic [1:0]           probe_attr,
  input logic                 upd_q,
  input logic                 cfg_lock
);

  localparam logic [MEM_AW-1:0] WIN_BASE = MEM_AW'((1 << MEM_AW) - (NUM_SEG << SEG_BITS));

  logic known_addr;
  assign known_addr = (cfg_addr == CFG_AW'(ADR_MEMCTL)) || (cfg_addr == CFG_AW'(ADR_AUX)) ||
                      (cfg_addr == CFG_AW'(ADR_GRANEN)) || (cfg_addr == CFG_AW'(ADR_XGRAN));

  AST_UNKNOWN_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !known_addr |-> cfg_rdata == '0); // R2

  AST_TABLE_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |=> $stable(seg_attr)); // R3

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_code
    AST_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      seg_attr[2*k +: 2] != 2'b11); // R3
  end

  AST_BASE_NEVER_RO: assert property (@(posedge clk) disable iff (!rst_n)
    seg_attr[1:0] != ATTR_RO); // R4

  AST_LOCKED_WRITE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_lock) |=> ##1 $stable(seg_attr)); // R7

  AST_LOW_MEM_RW: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_addr < WIN_BASE) |-> probe_attr == ATTR_RW); // R9

  AST_PROBE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_addr >= WIN_BASE) |->
      probe_attr == seg_attr[2*int'((probe_addr - WIN_BASE) >> SEG_BITS) +: 2]); // R9

endmodule

bind shadow_attr_ctrl shadow_attr_chk #(
  .CFG_AW(CFG_AW), .CFG_DW(CFG_DW), .MEM_AW(MEM_AW), .SEG_BITS(SEG_BITS), .NUM_SEG(NUM_SEG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_rdata(cfg_rdata),
  .seg_attr(seg_attr), .probe_addr(probe_addr), .probe_attr(probe_attr),
  .upd_q(upd_q), .cfg_lock(cfg_lock)
);

// File: tb/test_shadow_attr_ctrl.sv
module test_shadow_attr_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = 8'h00;
  logic [15:0] cfg_wdata = 16'h0000;
  logic [15:0] cfg_rdata;
  logic [31:0] seg_attr;
  logic [19:0] probe_addr = 20'h00000;
  logic [1:0]  probe_attr;
  logic [1:0]  sysrom_attr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Model state
  logic [15:0] m22, m28, m2c, m2e;
  logic [1:0]  mtab [16];

  always #10 clk = ~clk;

  shadow_attr_ctrl i_shadow_attr_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .seg_attr(seg_attr), .probe_addr(probe_addr),
    .probe_attr(probe_attr), .sysrom_attr(sysrom_attr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected attribute of an address, worked out from the address ranges
  function automatic logic [1:0] exp_attr(input logic [19:0] a);
    logic on;
    int s;
    if (a < 20'h80000) return 2'd1;
    if (a < 20'hA0000) return m22[3] ? 2'd1 : 2'd0;
    if (a < 20'hC0000) return !m22[10] ? 2'd0 : (m22[11] ? 2'd1 : 2'd2);
    if (m2c[0]) begin
      s = int'((a - 20'hC0000) / 20'h08000);
      if (!m2e[s + 8]) return 2'd0;
      return m2e[s] ? 2'd2 : 2'd1;
    end
    on = (a < 20'hE0000) ? m22[9] : m22[0];
    if (!on) return 2'd0;
    return m22[15] ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [31:0] packed_tab();
    logic [31:0] v;
    for (int k = 0; k < 16; k++) v[2*k +: 2] = mtab[k];
    return v;
  endfunction

  function automatic bit known(input logic [7:0] a);
    return a == 8'h22 || a == 8'h28 || a == 8'h2C || a == 8'h2E;
  endfunction

  task automatic recompute();
    for (int k = 0; k < 16; k++) mtab[k] = exp_attr(20'h80000 + 20'(k) * 20'h08000);
  endtask

  task automatic model_store(input logic [7:0] a, input logic [15:0] d);
    case (a)
      8'h22: m22 = d;
      8'h28: m28 = d;
      8'h2C: m2c = d;
      8'h2E: m2e = d;
      default: ;
    endcase
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cfg_wr = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m22 = 0; m28 = 16'h00F9; m2c = 0; m2e = 0;
    for (int k = 0; k < 16; k++) mtab[k] = 2'd0;
  endtask

  // Single write; optionally checks that the table has not yet moved one cycle later
  task automatic wr(input logic [7:0] a, input logic [15:0] d, input bit chk_mid);
    bit acc;
    acc = known(a) && !m22[15];
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
    model_store(a, d);
    if (chk_mid) check("R3 table before update edge", seg_attr, packed_tab());
    @(negedge clk);
    if (acc) recompute();
  endtask

  task automatic check_all(input string req);
    check(req, seg_attr, packed_tab());
    check("R10 system ROM segment", {30'd0, sysrom_attr},
          {30'd0, m22[8] ? mtab[12] : mtab[14]});
  endtask

  task automatic read_chk(input logic [7:0] a, input logic [15:0] exp, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(req, {16'd0, cfg_rdata}, {16'd0, exp});
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    do_reset();

    // R1 reset state
    read_chk(8'h22, 16'h0000, "R1 reg 0x22 reset");
    read_chk(8'h28, 16'h00F9, "R1 reg 0x28 reset");
    read_chk(8'h2C, 16'h0000, "R1 reg 0x2C reset");
    read_chk(8'h2E, 16'h0000, "R1 reg 0x2E reset");
    check("R1 table reset", seg_attr, 32'd0);

    // R2 readback and undefined address
    wr(8'h28, 16'hA55A, 1'b0);
    read_chk(8'h28, 16'hA55A, "R2 readback 0x28");
    wr(8'h2E, 16'h1234, 1'b0);
    read_chk(8'h2E, 16'h1234, "R2 readback 0x2E");
    wr(8'h24, 16'hFFFF, 1'b0);
    read_chk(8'h24, 16'h0000, "R2 undefined read zero");
    read_chk(8'h22, 16'h0000, "R2 undefined write leaves 0x22");
    check("R2 undefined write leaves table", seg_attr, packed_tab());

    // R3 update timing
    wr(8'h22, 16'h0008, 1'b1);
    check_all("R3 R4 table after update edge");

    // Coarse sweep over the relevant bits of 0x22: R4 R5 R6
    for (int c = 0; c < 128; c++) begin
      do_reset();
      v = 16'h0;
      v[0] = c[0]; v[3] = c[1]; v[8] = c[2]; v[9] = c[3];
      v[10] = c[4]; v[11] = c[5]; v[15] = c[6];
      wr(8'h22, v, 1'b0);
      check_all("R4 R5 R6 coarse decode");
    end

    // Extended sweep: R8
    for (int e = 0; e < 256; e++) begin
      do_reset();
      wr(8'h2C, 16'h0001, 1'b0);
      wr(8'h22, 16'h0C09 | 16'(e[0]) << 8, 1'b0);
      wr(8'h2E, {8'(e), 8'(e * 37 + 5)}, 1'b0);
      check_all("R8 extended segments");
    end

    // Lookup sweep on the last extended setting: R9
    for (int a = 0; a < 64; a++) begin
      @(negedge clk);
      probe_addr = 20'(a) * 20'h04000 + 20'h01234;
      #1;
      check("R9 probe lookup", {30'd0, probe_attr},
            {30'd0, (probe_addr < 20'h80000) ? 2'd1 : mtab[(probe_addr - 20'h80000) / 20'h08000]});
    end

    // Lock behaviour: R6 downgrade, R7 freeze and unlock
    do_reset();
    wr(8'h22, 16'h8201, 1'b0);
    check_all("R6 lock downgrades ROM shadows");
    wr(8'h22, 16'h0008, 1'b1);
    check_all("R7 write while locked ignored");
    read_chk(8'h22, 16'h0008, "R7 register stored while locked");
    wr(8'h22, 16'h0201, 1'b0);
    check_all("R7 unlocked write updates");

    // Back-to-back: lock-setting write, then a rejected write in the update cycle
    do_reset();
    wr(8'h2C, 16'h0001, 1'b0);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 8'h22; cfg_wdata = 16'h8000;
    @(negedge clk);
    model_store(8'h22, 16'h8000);
    recompute();
    cfg_addr = 8'h2E; cfg_wdata = 16'hFF0F;
    @(negedge clk);
    cfg_wr = 1'b0;
    model_store(8'h2E, 16'hFF0F);
    @(negedge clk);
    check_all("R7 R8 lock write then rejected write");
    read_chk(8'h2E, 16'hFF0F, "R2 R7 rejected write still stored");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule